// File: doc/BRIEF.md
# Power-Down and Wakeup Controller

This block sequences a small microcontroller subsystem into and out of a low-power state. Firmware asks for power-down with a one-cycle request. The block first gates the core clock, then drops the oscillator-enable and PLL-enable outputs. While the clock is gated, it watches three wakeup sources: a dedicated wakeup pin, a second wakeup pin that can be handed over to general-purpose I/O use, and a bus-activity indication. The controller runs on an always-on clock, and the analog oscillator and PLL are reduced to enable and lock handshakes.

When an enabled source asserts, the block re-enables the oscillator and PLL. It then waits for the synchronised PLL lock, or for a programmable timeout if lock never arrives. Only after that does it ungate the clock, and in the same cycle it raises a one-cycle wakeup interrupt. A wakeup that arrives while the entry sequence is still running cancels the entry. Each source keeps a sticky status flag that firmware clears by writing one. The dedicated pin behaves the same whether or not the bus is attached.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset, clk_en_o, osc_en_o and pll_en_o are 1, wake_irq_o is 0 and status_o is 0. The configuration resets to: all sources enabled, both pins active-low, pin 2 in wakeup mode, and the timeout at its maximum value.
- R2: A pd_req_i pulse in the run state drops clk_en_o at the next edge. osc_en_o and pll_en_o stay 1 for exactly ENTRY_CYC cycles with the clock gated, and then both drop to 0.
- R3: Every pin input passes through a two-flop synchroniser. In the sleep state, a qualifying source that changes just after an edge raises osc_en_o and pll_en_o on the third following edge. Source levels have no effect while the block is in the run state.
- R4: clk_en_o rises only once the synchronised lock is seen or the timeout expires. wake_irq_o is a one-cycle pulse that coincides with the rise of clk_en_o.
- R5: If lock stays low, the clock stays gated with the oscillator on for exactly cfg_tmo_i+1 cycles.
- R6: Polarity bit 0 applies to the dedicated pin and bit 1 to pin 2. A value of 0 means active-low and 1 means active-high. Bus activity is always active-high.
- R7: When cfg_gpio2_i is 1, pin 2 neither wakes the block nor sets its status flag.
- R8: Enable bit 0 gates the dedicated pin, bit 1 gates pin 2 and bit 2 gates bus activity. A disabled source neither wakes the block nor sets its status flag.
- R9: A status bit, with the same bit positions as the enables, is set when its source qualifies during entry or sleep. It stays set until a 1 is written to the same bit of stat_clr_i.
- R10: A qualifying source during the entry cycles returns the block to run, with clk_en_o restored and a wakeup interrupt, and osc_en_o never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_req_i | input | 1 | Power-down request pulse |
| cfg_we_i | input | 1 | Load the configuration fields |
| cfg_en_i | input | 3 | Per-source wakeup enables |
| cfg_pol_i | input | 2 | Pin polarity, 1 = active-high |
| cfg_gpio2_i | input | 1 | Pin 2 used as GPIO |
| cfg_tmo_i | input | TMO_W | Lock-wait timeout |
| stat_clr_i | input | 3 | Write-one-to-clear for status |
| wake_pin_i | input | 1 | Dedicated wakeup pin |
| wake2_pin_i | input | 1 | Second wakeup pin |
| bus_act_i | input | 1 | Bus activity indication |
| pll_lock_i | input | 1 | PLL lock, asynchronous |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| clk_en_o | output | 1 | Core clock ungate |
| wake_irq_o | output | 1 | Wakeup interrupt pulse |
| status_o | output | 3 | Sticky per-source wake flags |

## Verification
The assertions assume that pll_lock_i and the source pins are asynchronous levels that the block samples only through its synchronisers. They also assume that pd_req_i is a single-cycle pulse and that stat_clr_i carries pulses. The bench drives every input on the falling clock edge. It returns each source to its inactive level before it issues the next power-down request, and it raises lock only while the block waits in the wake state, so each measured latency comes from one known event.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned NUM_PIN = 2;
  localparam int unsigned SRC_PIN  = 0;
  localparam int unsigned SRC_PIN2 = 1;
  localparam int unsigned SRC_BUS  = 2;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wake_detect.sv
module wake_detect
  import pwr_wake_pkg::*;
(
  input  logic [NUM_PIN-1:0] pin_s_i,
  input  logic               bus_s_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_PIN-1:0] pol_i,
  input  logic               gpio2_i,
  output logic [NUM_SRC-1:0] evt_o
);
  logic [NUM_PIN-1:0] pin_act;

  for (genvar i = 0; i < NUM_PIN; i++) begin : g_pin
    // pol=1 active-high, pol=0 active-low
    if (i == SRC_PIN2) begin : g_muxed
      assign pin_act[i] = ~(pin_s_i[i] ^ pol_i[i]) & ~gpio2_i;
    end else begin : g_plain
      assign pin_act[i] = ~(pin_s_i[i] ^ pol_i[i]);
    end
    assign evt_o[i] = pin_act[i] & en_i[i];
  end

  assign evt_o[SRC_BUS] = bus_s_i & en_i[SRC_BUS];
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_wake_pkg::*;
#(
  parameter int unsigned ENTRY_CYC = 4,
  parameter int unsigned TMO_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_req_i,
  input  logic             wake_i,
  input  logic             lock_s_i,
  input  logic [TMO_W-1:0] tmo_i,
  output pwr_state_e       state_o,
  output logic             osc_en_o,
  output logic             pll_en_o,
  output logic             clk_en_o,
  output logic             irq_o
);
  localparam int unsigned EW = (ENTRY_CYC > 1) ? $clog2(ENTRY_CYC) : 1;
  localparam logic [EW-1:0] ECNT_LAST = EW'(ENTRY_CYC - 1);

  pwr_state_e       state_q, state_d;
  logic [EW-1:0]    ecnt_q, ecnt_d;
  logic [TMO_W-1:0] tcnt_q, tcnt_d;
  logic             irq_d;

  always_comb begin
    state_d = state_q;
    ecnt_d  = ecnt_q;
    tcnt_d  = tcnt_q;
    irq_d   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (pd_req_i) begin
          state_d = ST_ENTER;
          ecnt_d  = '0;
        end
      end
      ST_ENTER: begin
        if (wake_i) begin
          state_d = ST_RUN;   // abort entry
          irq_d   = 1'b1;
        end else if (ecnt_q == ECNT_LAST) begin
          state_d = ST_SLEEP;
        end else begin
          ecnt_d = ecnt_q + 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wake_i) begin
          state_d = ST_WAKE;
          tcnt_d  = '0;
        end
      end
      ST_WAKE: begin
        if (lock_s_i || tcnt_q == tmo_i) begin
          state_d = ST_RUN;
          irq_d   = 1'b1;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      ecnt_q  <= '0;
      tcnt_q  <= '0;
      irq_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      ecnt_q  <= ecnt_d;
      tcnt_q  <= tcnt_d;
      irq_o   <= irq_d;
    end
  end

  assign state_o  = state_q;
  assign osc_en_o = (state_q != ST_SLEEP);
  assign pll_en_o = (state_q != ST_SLEEP);
  assign clk_en_o = (state_q == ST_RUN);
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int unsigned ENTRY_CYC   = 4,
  parameter int unsigned TMO_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_req_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_en_i,
  input  logic [1:0]       cfg_pol_i,
  input  logic             cfg_gpio2_i,
  input  logic [TMO_W-1:0] cfg_tmo_i,
  input  logic [2:0]       stat_clr_i,
  input  logic             wake_pin_i,
  input  logic             wake2_pin_i,
  input  logic             bus_act_i,
  input  logic             pll_lock_i,
  output logic             osc_en_o,
  output logic             pll_en_o,
  output logic             clk_en_o,
  output logic             wake_irq_o,
  output logic [2:0]       status_o
);
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_PIN-1:0] pol_q;
  logic               gpio2_q;
  logic [TMO_W-1:0]   tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '1;
      pol_q   <= '0;
      gpio2_q <= 1'b0;
      tmo_q   <= '1;
    end else if (cfg_we_i) begin
      en_q    <= cfg_en_i;
      pol_q   <= cfg_pol_i;
      gpio2_q <= cfg_gpio2_i;
      tmo_q   <= cfg_tmo_i;
    end
  end

  logic [NUM_SRC-1:0] src_s;
  logic               lock_s;

  wake_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_src_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({bus_act_i, wake2_pin_i, wake_pin_i}),
    .q_o    (src_s)
  );

  wake_sync #(.W(1), .STAGES(SYNC_STAGES)) u_lock_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pll_lock_i),
    .q_o    (lock_s)
  );

  logic [NUM_SRC-1:0] evt;

  wake_detect u_detect (
    .pin_s_i (src_s[NUM_PIN-1:0]),
    .bus_s_i (src_s[SRC_BUS]),
    .en_i    (en_q),
    .pol_i   (pol_q),
    .gpio2_i (gpio2_q),
    .evt_o   (evt)
  );

  pwr_state_e state;

  pwr_fsm #(.ENTRY_CYC(ENTRY_CYC), .TMO_W(TMO_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pd_req_i (pd_req_i),
    .wake_i   (|evt),
    .lock_s_i (lock_s),
    .tmo_i    (tmo_q),
    .state_o  (state),
    .osc_en_o (osc_en_o),
    .pll_en_o (pll_en_o),
    .clk_en_o (clk_en_o),
    .irq_o    (wake_irq_o)
  );

  // events only count while the clock is gated for entry or sleep
  logic               trig;
  logic [NUM_SRC-1:0] stat_q;

  assign trig = (state == ST_ENTER) || (state == ST_SLEEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~stat_clr_i) | (evt & {NUM_SRC{trig}});
  end

  assign status_o = stat_q;
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       osc_en_o,
  input logic       pll_en_o,
  input logic       clk_en_o,
  input logic       wake_irq_o,
  input logic [2:0] status_o,
  input logic [2:0] stat_clr_i,
  input logic       gpio2_q_i
);
  p_clk_needs_osc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> (osc_en_o && pll_en_o));

  p_osc_before_clk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> !clk_en_o);

  p_clk_rise_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> wake_irq_o);

  p_irq_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |=> !wake_irq_o);

  p_gate_before_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> (!clk_en_o && $past(!clk_en_o)));

  p_gpio_no_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> !$past(gpio2_q_i));

  for (genvar i = 0; i < 3; i++) begin : g_st
    p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_o[i]) |-> $past(stat_clr_i[i]));
  end
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .osc_en_o   (osc_en_o),
  .pll_en_o   (pll_en_o),
  .clk_en_o   (clk_en_o),
  .wake_irq_o (wake_irq_o),
  .status_o   (status_o),
  .stat_clr_i (stat_clr_i),
  .gpio2_q_i  (gpio2_q)
);

// File: tb/pwr_wake_ctrl_bench.sv
module pwr_wake_ctrl_bench;
  localparam int unsigned ENTRY_CYC = 4;
  localparam int unsigned TMO_W     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 0, cfg_we = 0, gpio2 = 0;
  logic [2:0] en = 3'b111, clr = '0;
  logic [1:0] pol = '0;
  logic [TMO_W-1:0] tmo = '1;
  logic pin = 1, pin2 = 1, bus = 0, lock = 0;
  logic osc_en, pll_en, clk_en, irq;
  logic [2:0] status;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pwr_wake_ctrl #(.ENTRY_CYC(ENTRY_CYC), .TMO_W(TMO_W)) u_pwr_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_i(pd_req), .cfg_we_i(cfg_we),
    .cfg_en_i(en), .cfg_pol_i(pol), .cfg_gpio2_i(gpio2), .cfg_tmo_i(tmo),
    .stat_clr_i(clr), .wake_pin_i(pin), .wake2_pin_i(pin2), .bus_act_i(bus),
    .pll_lock_i(lock), .osc_en_o(osc_en), .pll_en_o(pll_en), .clk_en_o(clk_en),
    .wake_irq_o(irq), .status_o(status)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic set_cfg(input logic [2:0] e, input logic [1:0] p, input logic g, input int t);
    @(negedge clk);
    en = e; pol = p; gpio2 = g; tmo = TMO_W'(t); cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clear_status();
    @(negedge clk); clr = 3'b111;
    @(negedge clk); clr = 3'b000;
  endtask

  task automatic idle_src(input logic [1:0] p);
    pin = ~p[0]; pin2 = ~p[1]; bus = 0;
  endtask

  task automatic drive_src(input int s, input logic [1:0] p, input logic act);
    if (s == 0)      pin  = act ? p[0] : ~p[0];
    else if (s == 1) pin2 = act ? p[1] : ~p[1];
    else             bus  = act;
  endtask

  // returns number of cycles gated with oscillator still running
  task automatic enter_sleep(output int len);
    @(negedge clk); pd_req = 1;
    @(negedge clk); pd_req = 0;
    len = 0;
    while (!clk_en && osc_en && len < 50) begin
      len++; @(negedge clk);
    end
  endtask

  // caller has just driven a source at a negedge
  task automatic wait_wake(input logic raise_lock, output int pre, output int wk,
                           output int irq1, output int irq2);
    pre = 0;
    @(negedge clk);
    while (!osc_en && pre < 20) begin
      pre++; @(negedge clk);
    end
    if (raise_lock) lock = 1;
    wk = 0;
    while (!clk_en && wk < 300) begin
      wk++; @(negedge clk);
    end
    irq1 = irq;
    @(negedge clk);
    irq2 = irq;
    lock = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int len, pre, wk, i1, i2;
    repeat (3) @(negedge clk);
    check("R1 clk_en", clk_en, 1);
    check("R1 osc_en", osc_en, 1);
    check("R1 pll_en", pll_en, 1);
    check("R1 irq", irq, 0);
    check("R1 status", status, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // default configuration: active-low dedicated pin, max timeout
    enter_sleep(len);
    check("R2 entry length", len, ENTRY_CYC);
    check("R2 pll_en off", pll_en, 0);
    check("R2 osc_en off", osc_en, 0);
    pin = 0;
    wait_wake(0, pre, wk, i1, i2);
    check("R3 wake latency", pre, 2);
    check("R5 default timeout", wk, (1 << TMO_W));
    check("R4 irq at ungate", i1, 1);
    check("R4 irq one cycle", i2, 0);
    check("R9 status set", status, 1);
    pin = 1;
    repeat (3) @(negedge clk);
    check("R9 status sticky", status, 1);
    clear_status();
    check("R9 status cleared", status, 0);

    // timeout sweep
    for (int t = 0; t < (1 << TMO_W); t++) begin
      set_cfg(3'b111, 2'b00, 0, t);
      enter_sleep(len);
      bus = 1;
      wait_wake(0, pre, wk, i1, i2);
      check("R5 timeout sweep", wk, t + 1);
      check("R4 irq sweep", i1, 1);
      bus = 0;
      clear_status();
    end

    // lock ends the wait early
    set_cfg(3'b111, 2'b00, 0, (1 << TMO_W) - 1);
    enter_sleep(len);
    bus = 1;
    wait_wake(1, pre, wk, i1, i2);
    check("R4 lock ends wait", wk, 3);
    check("R4 irq on lock", i1, 1);
    bus = 0;
    clear_status();

    // source / enable / polarity / gpio sweep
    for (int e = 0; e < 8; e++)
      for (int s = 0; s < 3; s++)
        for (int p = 0; p < 2; p++)
          for (int g = 0; g < 2; g++) begin
            logic [1:0] pv;
            int exp_w, n;
            string tag;
            if (s == 2 && p == 1) continue;
            pv = {p[0], p[0]};
            exp_w = (e[s] && !(s == 1 && g == 1)) ? 1 : 0;
            tag = (s == 1 && g == 1) ? "R7 gpio pin2" : (!e[s] ? "R8 disabled src" : "R6 polarity src");
            idle_src(pv);
            set_cfg(3'(e), pv, g[0], (1 << TMO_W) - 1);
            clear_status();
            enter_sleep(len);
            drive_src(s, pv, 1);
            repeat (8) @(negedge clk);
            check(tag, osc_en, exp_w);
            check(tag, status, exp_w << s);
            if (exp_w == 0) begin
              drive_src(s, pv, 0);
              set_cfg(3'b111, pv, 0, (1 << TMO_W) - 1);
              drive_src(0, pv, 1);
            end
            n = 0;
            while (!clk_en && n < 100) begin n++; @(negedge clk); end
            idle_src(pv);
            repeat (3) @(negedge clk);
            clear_status();
          end

    // events in run state have no effect
    idle_src(2'b00);
    set_cfg(3'b111, 2'b00, 0, (1 << TMO_W) - 1);
    clear_status();
    begin
      int irq_seen = 0, gated = 0;
      pin = 0; bus = 1;
      repeat (6) begin
        @(negedge clk);
        if (irq) irq_seen = 1;
        if (!clk_en) gated = 1;
      end
      check("R3 run ignores irq", irq_seen, 0);
      check("R3 run ignores clk", gated, 0);
      check("R3 run ignores status", status, 0);
      pin = 1; bus = 0;
      repeat (3) @(negedge clk);
    end

    // wakeup during entry aborts
    begin
      int n = 0, osc_low = 0;
      @(negedge clk); pd_req = 1;
      @(negedge clk); pd_req = 0; pin = 0;
      while (!clk_en && n < 20) begin
        if (!osc_en) osc_low = 1;
        n++; @(negedge clk);
      end
      check("R10 abort cycles", n, 3);
      check("R10 osc kept", osc_low, 0);
      check("R10 irq", irq, 1);
      check("R10 status", status, 1);
      pin = 1;
      repeat (3) @(negedge clk);
    end

    summary();
  end
endmodule